// File: doc/BRIEF.md
# Gated-Clock Parallel-to-Serial Shift Register

This block turns an eight-bit parallel word into a serial bit stream. A level-sensitive load control copies the eight parallel inputs into the stages and overrides any clocking. With the load control released, the register advances one position toward its last stage on every rising edge of a gated clock. That gated clock is the OR of two inputs, a clock pin and an inhibit pin, and either one can act as the clock. A serial input feeds the first stage. The last stage drives a true serial output and its complement.

All external control and data pins are asynchronous to the system clock. A two-flop synchronizer brings them into the system domain. A rising edge of the gated clock is then detected as the synchronized value of (clock OR inhibit) changing from 0 to 1 between two consecutive system clocks. The stage contents are visible on a parallel output for observation.

Top module: `psr_shift8`

## Requirements
- R1: While `rst_n` is low, every stage reads 0, `ser_o` is 0 and `ser_n_o` is 1.
- R2: While `load_n_i` is low, the stages follow `par_i`. Bit `par_i[0]` goes to the first stage `q_o[0]`, and bit `par_i[7]` goes to the last stage `q_o[7]`. A change on `par_i` during the load appears in the stages.
- R3: While `load_n_i` is low, rising edges on `ext_clk_i` or `clk_inh_i` and changes on `ser_i` have no effect. The stages still equal `par_i`.
- R4: With `load_n_i` high and `clk_inh_i` low, a rising edge on `ext_clk_i` causes one shift. After the shift, `q_o[0]` holds `ser_i` and every `q_o[k]` holds the old `q_o[k-1]`.
- R5: With `load_n_i` high and `ext_clk_i` low, a rising edge on `clk_inh_i` causes exactly one shift, the same as R4.
- R6: A rising edge on `clk_inh_i` while `ext_clk_i` is high does not shift. A falling edge of either input does not shift.
- R7: `ser_o` always equals the last stage `q_o[7]`, and `ser_n_o` is always its inverse.
- R8: With `load_n_i` high and no rising edge of the gated clock, every stage keeps its value, whatever `ser_i` does.
- R9: A pin change made just before system clock edge k appears on the outputs after edge k+2, and not earlier. This covers two synchronizer flops and one stage register.
- R10: Suppose a gated-clock rising edge is detected in the same system cycle in which the synchronized load is still active. The load wins, and that edge never causes a shift, even after the load is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External shift clock, asynchronous |
| clk_inh_i | input | 1 | Clock inhibit; interchangeable with ext_clk_i |
| load_n_i | input | 1 | Load control: low loads par_i, high allows shifting |
| ser_i | input | 1 | Serial data into the first stage |
| par_i | input | 8 | Parallel data; bit 0 goes to the first stage |
| q_o | output | 8 | Stage contents; bit 0 is the first stage, bit 7 the last |
| ser_o | output | 1 | Serial output (last stage) |
| ser_n_o | output | 1 | Complemented serial output |

## Verification
The checker verifies four properties on every cycle after reset, using the synchronized signals:
- a load leaves the stages equal to the sampled parallel word;
- a detected edge with the load released makes exactly a one-position shift;
- the register holds when no edge arrives;
- a rise of the inhibit with the clock already high never produces an edge.

It also checks that the two serial outputs are always complementary copies of the last stage.

Only the directed scenarios show the pin-level behaviour:
- the exact three-cycle latency from a pin change to the outputs;
- that the inhibit pin acts as a clock;
- that a load released just after a clock edge swallows that edge;
- the reset values seen at the ports.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned PSR_STAGES     = 8;
  localparam int unsigned PSR_SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_SHIFT = 2'd2
  } stage_op_e;
endpackage

// File: rtl/psr_sync.sv
module psr_sync #(
  parameter int unsigned W     = 1,
  parameter int unsigned DEPTH = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_flop
    logic [W-1:0] nxt;
    if (s == 0) begin : g_first
      assign nxt = d_i;
    end else begin : g_rest
      assign nxt = pipe[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[s] <= RST_VAL;
      else        pipe[s] <= nxt;
    end
  end

  assign q_o = pipe[DEPTH-1];
endmodule

// File: rtl/psr_gate_edge.sv
module psr_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_s_i,
  input  logic inh_s_i,
  output logic rise_o
);
  logic gate_cur;
  logic gate_prev;
  logic gate_prev_nxt;

  always_comb begin
    gate_cur      = clk_s_i | inh_s_i;
    gate_prev_nxt = gate_cur;
    rise_o        = gate_cur & ~gate_prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_prev <= 1'b0;
    else        gate_prev <= gate_prev_nxt;
  end
endmodule

// File: rtl/psr_stages.sv
module psr_stages
  import psr_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_n_i,
  input  logic         rise_i,
  input  logic         ser_i,
  input  logic [N-1:0] par_i,
  output logic [N-1:0] q_o
);
  stage_op_e    op;
  logic         q_en;
  logic [N-1:0] q_nxt;
  logic [N-1:0] q_r;

  always_comb begin
    if (!load_n_i)   op = OP_LOAD;
    else if (rise_i) op = OP_SHIFT;
    else             op = OP_HOLD;
  end

  always_comb begin
    q_en  = 1'b0;
    q_nxt = q_r;
    unique case (op)
      OP_LOAD: begin
        q_en  = 1'b1;
        q_nxt = par_i;
      end
      OP_SHIFT: begin
        q_en  = 1'b1;
        q_nxt = {q_r[N-2:0], ser_i};
      end
      default: begin
        q_en  = 1'b0;
        q_nxt = q_r;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  assign q_o = q_r;
endmodule

// File: rtl/psr_shift8.sv
module psr_shift8
  import psr_pkg::*;
#(
  parameter int unsigned STAGES     = PSR_STAGES,
  parameter int unsigned SYNC_DEPTH = PSR_SYNC_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_clk_i,
  input  logic              clk_inh_i,
  input  logic              load_n_i,
  input  logic              ser_i,
  input  logic [STAGES-1:0] par_i,
  output logic [STAGES-1:0] q_o,
  output logic              ser_o,
  output logic              ser_n_o
);
  localparam int unsigned BW = STAGES + 4;
  localparam logic [BW-1:0] SYNC_RST = {1'b1, {(BW-1){1'b0}}};

  logic [BW-1:0]     raw_bus;
  logic [BW-1:0]     sync_bus;
  logic              load_n_s;
  logic              clk_s;
  logic              inh_s;
  logic              ser_s;
  logic [STAGES-1:0] par_s;
  logic              rise;
  logic [STAGES-1:0] q;

  assign raw_bus = {load_n_i, ext_clk_i, clk_inh_i, ser_i, par_i};

  psr_sync #(
    .W      (BW),
    .DEPTH  (SYNC_DEPTH),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (raw_bus),
    .q_o  (sync_bus)
  );

  assign {load_n_s, clk_s, inh_s, ser_s, par_s} = sync_bus;

  psr_gate_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_s_i(clk_s),
    .inh_s_i(inh_s),
    .rise_o (rise)
  );

  psr_stages #(.N(STAGES)) u_stages (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_n_i(load_n_s),
    .rise_i  (rise),
    .ser_i   (ser_s),
    .par_i   (par_s),
    .q_o     (q)
  );

  assign q_o     = q;
  assign ser_o   = q[STAGES-1];
  assign ser_n_o = ~q[STAGES-1];
endmodule

// File: rtl/psr_shift8_chk.sv
module psr_shift8_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load_n_s,
  input logic         clk_s,
  input logic         rise,
  input logic         ser_s,
  input logic [N-1:0] par_s,
  input logic [N-1:0] q_o,
  input logic         ser_o,
  input logic         ser_n_o
);
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n_s |=> (q_o == $past(par_s)));  // R2

  AST_SHIFT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n_s && rise) |=> (q_o == {$past(q_o[N-2:0]), $past(ser_s)}));  // R4

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n_s && !rise) |=> $stable(q_o));  // R8

  AST_INH_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_s && $past(clk_s)) |-> !rise);  // R6

  AST_SERIAL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_o == q_o[N-1]) && (ser_n_o != ser_o));  // R7
endmodule

bind psr_shift8 psr_shift8_chk #(.N(STAGES)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .load_n_s(load_n_s),
  .clk_s   (clk_s),
  .rise    (rise),
  .ser_s   (ser_s),
  .par_s   (par_s),
  .q_o     (q_o),
  .ser_o   (ser_o),
  .ser_n_o (ser_n_o)
);

// File: tb/sim_psr_shift8.sv
`timescale 1ns/1ps
module sim_psr_shift8;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_clk_i, clk_inh_i, load_n_i, ser_i;
  logic [7:0] par_i;
  logic [7:0] q_o;
  logic       ser_o, ser_n_o;
  logic [7:0] m;
  int         total = 0;
  int         fails = 0;

  always #2 clk = ~clk;

  psr_shift8 u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_clk_i(ext_clk_i),
    .clk_inh_i(clk_inh_i),
    .load_n_i (load_n_i),
    .ser_i    (ser_i),
    .par_i    (par_i),
    .q_o      (q_o),
    .ser_o    (ser_o),
    .ser_n_o  (ser_n_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_serial(input string req);
    chk(req, {31'd0, ser_o},   {31'd0, m[7]});
    chk(req, {31'd0, ser_n_o}, {31'd0, ~m[7]});
  endtask

  task automatic pulse_clk(input logic b);
    ser_i = b; cyc(4);
    ext_clk_i = 1'b1; cyc(4);
    m = {m[6:0], b};
    ext_clk_i = 1'b0; cyc(4);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ext_clk_i = 0; clk_inh_i = 0; load_n_i = 1; ser_i = 0; par_i = 8'h00;
    cyc(3);
    chk("R1 q", {24'd0, q_o}, 32'd0);
    chk("R1 ser", {31'd0, ser_o}, 32'd0);
    chk("R1 ser_n", {31'd0, ser_n_o}, 32'd1);
    rst_n = 1'b1; cyc(4);
    m = 8'h00;
  endtask

  task automatic t_load;
    par_i = 8'hA5; load_n_i = 1'b0; cyc(4);
    m = 8'hA5;
    chk("R2 load", {24'd0, q_o}, {24'd0, m});
    par_i = 8'h3C; cyc(4);
    m = 8'h3C;
    chk("R2 follow", {24'd0, q_o}, {24'd0, m});
    ser_i = 1'b1; ext_clk_i = 1'b1; cyc(4);
    ext_clk_i = 1'b0; clk_inh_i = 1'b1; cyc(4);
    clk_inh_i = 1'b0; ser_i = 1'b0; cyc(4);
    chk("R3 override", {24'd0, q_o}, {24'd0, m});
    chk_serial("R7 load");
    load_n_i = 1'b1; cyc(4);
    chk("R8 release", {24'd0, q_o}, {24'd0, m});
  endtask

  task automatic t_shift_clk;
    logic [7:0] pat = 8'b1101_0010;
    for (int i = 0; i < 8; i++) begin
      pulse_clk(pat[i]);
      chk("R4 shift", {24'd0, q_o}, {24'd0, m});
      chk_serial("R7 shift");
    end
  endtask

  task automatic t_latency;
    ser_i = ~m[0]; cyc(4);
    @(negedge clk); ext_clk_i = 1'b1;
    cyc(2);
    chk("R9 early", {24'd0, q_o}, {24'd0, m});
    cyc(1);
    m = {m[6:0], ser_i};
    chk("R9 on time", {24'd0, q_o}, {24'd0, m});
    ext_clk_i = 1'b0; cyc(4);
  endtask

  task automatic t_inh_shift;
    ser_i = 1'b1; cyc(4);
    clk_inh_i = 1'b1; cyc(4);
    m = {m[6:0], 1'b1};
    chk("R5 inh clocks", {24'd0, q_o}, {24'd0, m});
    clk_inh_i = 1'b0; cyc(4);
    chk("R5 single", {24'd0, q_o}, {24'd0, m});
  endtask

  task automatic t_inh_block;
    ser_i = 1'b0; cyc(4);
    ext_clk_i = 1'b1; cyc(4);
    m = {m[6:0], 1'b0};
    chk("R4 edge", {24'd0, q_o}, {24'd0, m});
    clk_inh_i = 1'b1; cyc(4);
    chk("R6 inh high", {24'd0, q_o}, {24'd0, m});
    ext_clk_i = 1'b0; cyc(4);
    chk("R6 clk fall", {24'd0, q_o}, {24'd0, m});
    clk_inh_i = 1'b0; cyc(4);
    chk("R6 inh fall", {24'd0, q_o}, {24'd0, m});
  endtask

  task automatic t_hold;
    for (int i = 0; i < 6; i++) begin
      ser_i = ~ser_i; cyc(3);
    end
    chk("R8 hold", {24'd0, q_o}, {24'd0, m});
    chk_serial("R7 hold");
  endtask

  task automatic t_priority;
    par_i = 8'h69; load_n_i = 1'b0; ser_i = 1'b1; cyc(4);
    ext_clk_i = 1'b1; cyc(1);
    load_n_i = 1'b1; cyc(6);
    m = 8'h69;
    chk("R10 load wins", {24'd0, q_o}, {24'd0, m});
    ext_clk_i = 1'b0; cyc(4);
    chk("R10 no late shift", {24'd0, q_o}, {24'd0, m});
  endtask

  initial begin
    #(4 * 150000);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_reset();
    t_load();
    t_shift_clk();
    t_latency();
    t_inh_shift();
    t_inh_block();
    t_hold();
    t_priority();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule